// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider Controller

This block sits in the feedback path of a frequency synthesizer, behind an external dual-modulus prescaler that divides the oscillator by either 8 or 9. It runs on the prescaler's output clock. It drives the prescaler's modulus select so that each division cycle covers a programmed number of oscillator periods. At the end of every division cycle it emits one divided-output pulse, which goes to the phase detector.

A single mode bit selects between two kinds of operation. In integer mode every cycle divides by the programmed ratio N. In fractional mode a 12-bit accumulator adds a numerator once per division cycle. Each carry out of the accumulator lengthens that one cycle by a single oscillator period, so the long-run average ratio is N plus the numerator divided by 4096.

New settings are captured on a load strobe. They take effect only at the next division-cycle boundary, so a cycle in progress is never disturbed.

Top module: `fnd_frac_divider`

## Requirements
- R1: While reset is held, and right after it is released, the modulus select is low (divide-by-8) and the divided pulse is low. The first full cycle after reset divides by 72 until a load is made.
- R2: In integer mode, each division cycle spans exactly N oscillator periods for every N from 72 to 32767. The cycle consists of N div 8 prescaler-clock periods, and the modulus select is high (divide-by-9) in exactly N mod 8 of them.
- R3: Within one division cycle, every divide-by-9 period comes before every divide-by-8 period.
- R4: A programmed ratio below 72 is raised to 72. In fractional mode, a ratio above 1008 is lowered to 1008.
- R5: In fractional mode with numerator F and an accumulator starting at zero, cycle k (counting from 1) divides by N + floor(k·F/4096) − floor((k−1)·F/4096).
- R6: A division cycle that starts with the mode bit low clears the accumulator. A later return to fractional mode therefore starts its carry pattern from zero.
- R7: Settings captured by the load strobe at the same clock edge that ends a division cycle do not affect the cycle that begins at that edge. They apply from the following cycle onward. The accumulator changes only at cycle boundaries.
- R8: The divided pulse is high for exactly one prescaler-clock period, the last period of each division cycle.
- R9: In fractional mode, every integer part from 72 to 1008 is accepted, including 1008 with a carry giving 1009.
- R10: Over K fractional cycles from a cleared accumulator, the total count of oscillator periods equals K·N + floor(K·F/4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frac_en_i | input | 1 | 1 = fractional mode, 0 = integer mode |
| int_ratio_i | input | 15 | Integer division ratio N |
| frac_num_i | input | 12 | Fractional numerator F (modulus 4096) |
| load_i | input | 1 | Captures frac_en_i, int_ratio_i and frac_num_i at the clock edge |
| mod_sel_o | output | 1 | Prescaler modulus select: 1 = divide by 9, 0 = divide by 8 |
| div_pulse_o | output | 1 | One-period pulse marking the last period of each division cycle |

## Verification
An integer sweep over every ratio from 72 to 151 covers all eight swallow counts against the smallest main counts. This separates a miscount in the swallow phase from one in the main phase. Single loads of 32767, 0, 71 and 2000 probe the top of the counter range and both clamps.

Fractional runs use F = 1 over the full 4096 cycles, which yields a single carry at the very end. F = 2048 alternates carries, and F = 4095 and 1365 produce dense and irregular carry patterns. Each cycle is compared against the floor formula, which exposes an accumulator that is off by one or that fails to wrap.

A repeat of F = 2048 after an integer interlude tells a cleared accumulator apart from a stale one. The cycle measured immediately after each load shows whether settings take effect early.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int unsigned DEF_NW        = 15;
  localparam int unsigned DEF_AW        = 12;
  localparam int unsigned DEF_NMIN      = 72;
  localparam int unsigned DEF_NMAX_INT  = 32767;
  localparam int unsigned DEF_NMAX_FRAC = 1008;
  localparam int unsigned DEF_PS_SHIFT  = 3;

  function automatic int unsigned clamp_ratio(input int unsigned r,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (r < lo)      return lo;
    else if (r > hi) return hi;
    else             return r;
  endfunction
endpackage

// File: rtl/fnd_cfg_stage.sv
module fnd_cfg_stage
  import fnd_pkg::*;
#(
  parameter int unsigned NW        = DEF_NW,
  parameter int unsigned AW        = DEF_AW,
  parameter int unsigned NMIN      = DEF_NMIN,
  parameter int unsigned NMAX_INT  = DEF_NMAX_INT,
  parameter int unsigned NMAX_FRAC = DEF_NMAX_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          frac_en_i,
  input  logic [NW-1:0] ratio_i,
  input  logic [AW-1:0] num_i,
  output logic          frac_en_o,
  output logic [NW-1:0] ratio_o,
  output logic [AW-1:0] num_o
);
  localparam logic [NW-1:0] MIN_V  = NW'(NMIN);
  localparam logic [NW-1:0] MAXI_V = NW'(NMAX_INT);
  localparam logic [NW-1:0] MAXF_V = NW'(NMAX_FRAC);

  logic          frac_q, frac_d;
  logic [NW-1:0] ratio_q, ratio_d, ratio_cl;
  logic [AW-1:0] num_q, num_d;

  always_comb begin
    ratio_cl = NW'(clamp_ratio(int'(ratio_i), NMIN,
                               frac_en_i ? NMAX_FRAC : NMAX_INT));
    frac_d  = frac_q;
    ratio_d = ratio_q;
    num_d   = num_q;
    if (load_i) begin
      frac_d  = frac_en_i;
      ratio_d = ratio_cl;
      num_d   = num_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q  <= 1'b0;
      ratio_q <= MIN_V;
      num_q   <= '0;
    end else begin
      frac_q  <= frac_d;
      ratio_q <= ratio_d;
      num_q   <= num_d;
    end
  end

  assign frac_en_o = frac_q;
  assign ratio_o   = ratio_q;
  assign num_o     = num_q;

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q >= MIN_V) && (ratio_q <= (frac_q ? MAXF_V : MAXI_V))); // R4
endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc
  import fnd_pkg::*;
#(
  parameter int unsigned AW = DEF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          frac_en_i,
  input  logic [AW-1:0] num_i,
  output logic          carry_o
);
  logic [AW-1:0] acc_q, acc_d;
  logic [AW:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, num_i};
    carry_o = frac_en_i & sum[AW];
    acc_d   = acc_q;
    if (step_i) acc_d = frac_en_i ? sum[AW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !frac_en_i) |=> (acc_q == '0)); // R6
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(acc_q)); // R7
endmodule

// File: rtl/fnd_swallow_ctr.sv
module fnd_swallow_ctr
  import fnd_pkg::*;
#(
  parameter int unsigned NW       = DEF_NW,
  parameter int unsigned NMIN     = DEF_NMIN,
  parameter int unsigned PS_SHIFT = DEF_PS_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] next_ratio_i,
  output logic          mod_o,
  output logic          end_o
);
  localparam int unsigned CW = NW - PS_SHIFT;
  localparam logic [NW-1:0] MIN_V = NW'(NMIN);

  logic [CW-1:0]       cnt_q, cnt_d, main_q, main_d;
  logic [PS_SHIFT-1:0] swal_q, swal_d;
  logic [CW-1:0]       swal_ext;

  always_comb begin
    swal_ext = {{(CW-PS_SHIFT){1'b0}}, swal_q};
    mod_o    = cnt_q < swal_ext;
    end_o    = cnt_q == (main_q - CW'(1));
    cnt_d    = cnt_q + CW'(1);
    main_d   = main_q;
    swal_d   = swal_q;
    if (end_o) begin
      cnt_d  = '0;
      main_d = next_ratio_i[NW-1:PS_SHIFT];
      swal_d = next_ratio_i[PS_SHIFT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      main_q <= MIN_V[NW-1:PS_SHIFT];
      swal_q <= MIN_V[PS_SHIFT-1:0];
    end else begin
      cnt_q  <= cnt_d;
      main_q <= main_d;
      swal_q <= swal_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < main_q); // R2
  AST_SWALLOW_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    main_q > swal_ext); // R2
  AST_SWALLOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_o && !end_o) |=> !mod_o); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o); // R8
endmodule

// File: rtl/fnd_frac_divider.sv
module fnd_frac_divider
  import fnd_pkg::*;
#(
  parameter int unsigned NW        = DEF_NW,
  parameter int unsigned AW        = DEF_AW,
  parameter int unsigned NMIN      = DEF_NMIN,
  parameter int unsigned NMAX_INT  = DEF_NMAX_INT,
  parameter int unsigned NMAX_FRAC = DEF_NMAX_FRAC,
  parameter int unsigned PS_SHIFT  = DEF_PS_SHIFT
) (
  input  logic          pclk_i,
  input  logic          rst_ni,
  input  logic          frac_en_i,
  input  logic [NW-1:0] int_ratio_i,
  input  logic [AW-1:0] frac_num_i,
  input  logic          load_i,
  output logic          mod_sel_o,
  output logic          div_pulse_o
);
  logic [1:0]    rst_pipe;
  logic          rst_n;
  logic          stg_frac, carry, cyc_end;
  logic [NW-1:0] stg_ratio, next_ratio;
  logic [AW-1:0] stg_num;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  fnd_cfg_stage #(
    .NW(NW), .AW(AW), .NMIN(NMIN), .NMAX_INT(NMAX_INT), .NMAX_FRAC(NMAX_FRAC)
  ) u_cfg (
    .clk(pclk_i), .rst_n(rst_n), .load_i(load_i), .frac_en_i(frac_en_i),
    .ratio_i(int_ratio_i), .num_i(frac_num_i),
    .frac_en_o(stg_frac), .ratio_o(stg_ratio), .num_o(stg_num)
  );

  fnd_frac_acc #(.AW(AW)) u_acc (
    .clk(pclk_i), .rst_n(rst_n), .step_i(cyc_end), .frac_en_i(stg_frac),
    .num_i(stg_num), .carry_o(carry)
  );

  assign next_ratio = stg_ratio + NW'(carry);

  fnd_swallow_ctr #(.NW(NW), .NMIN(NMIN), .PS_SHIFT(PS_SHIFT)) u_ctr (
    .clk(pclk_i), .rst_n(rst_n), .next_ratio_i(next_ratio),
    .mod_o(mod_sel_o), .end_o(cyc_end)
  );

  assign div_pulse_o = cyc_end;

  AST_INT_NO_CARRY: assert property (@(posedge pclk_i) disable iff (!rst_n)
    !stg_frac |-> !carry); // R5
  AST_RESET_QUIET: assert property (@(posedge pclk_i)
    !rst_n |-> (!mod_sel_o && !div_pulse_o)); // R1
endmodule

// File: tb/fnd_frac_divider_tb.sv
module fnd_frac_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frac_en, load;
  logic [14:0] ratio_in;
  logic [11:0] num_in;
  logic        mod_sel, div_pulse;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fnd_frac_divider u_dut (
    .pclk_i(clk), .rst_ni(rst_n), .frac_en_i(frac_en), .int_ratio_i(ratio_in),
    .frac_num_i(num_in), .load_i(load), .mod_sel_o(mod_sel), .div_pulse_o(div_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int ratio, output int nines, output bit bad);
    bit seen8 = 1'b0;
    ratio = 0; nines = 0; bad = 1'b0;
    do begin
      @(negedge clk);
      load = 1'b0;
      if (mod_sel) begin
        nines++; ratio += 9;
        if (seen8) bad = 1'b1;
      end else begin
        seen8 = 1'b1; ratio += 8;
      end
    end while (!div_pulse);
  endtask

  task automatic check_cycle(input int exp, input string req, output int got);
    int nines; bit bad;
    measure(got, nines, bad);
    check(got == exp, req, got, exp);
    check(nines == exp % 8, {req, " R2 divide-by-9 count"}, nines, exp % 8);
    check(!bad, "R3 swallow order", int'(bad), 0);
  endtask

  task automatic set_cfg(input bit f, input int n, input int num);
    frac_en  = f;
    ratio_in = n[14:0];
    num_in   = num[11:0];
    load     = 1'b1;
  endtask

  task automatic go_int(input int n, input int exp, input string req);
    int r, nn; bit b;
    set_cfg(1'b0, n, 0);
    measure(r, nn, b);
    check_cycle(exp, req, r);
  endtask

  task automatic frac_test(input int n, input int f, input int cycles, input string req);
    int got; longint total = 0;
    go_int(n, n, "R2");
    set_cfg(1'b1, n, f);
    check_cycle(n, "R7 old ratio kept", got);
    for (int k = 1; k <= cycles; k++) begin
      int exp = n + ((k * f) >> 12) - (((k - 1) * f) >> 12);
      check_cycle(exp, req, got);
      total += got;
    end
    check(total == longint'(cycles) * n + ((longint'(cycles) * f) >> 12), "R10 total",
          int'(total), cycles * n + ((cycles * f) >> 12));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int got, nn; bit b;
    rst_n = 1'b0; load = 1'b0; frac_en = 1'b0; ratio_in = '0; num_in = '0;
    repeat (3) @(negedge clk);
    check(!mod_sel, "R1 reset mod", int'(mod_sel), 0);
    check(!div_pulse, "R1 reset pulse", int'(div_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mod_sel && !div_pulse, "R1 after release", int'(mod_sel | div_pulse), 0);
    measure(got, nn, b);
    check_cycle(72, "R1 default ratio", got);
    // R7: load at the ending edge keeps the new cycle on the old ratio
    set_cfg(1'b0, 100, 0);
    check_cycle(72, "R7 old ratio kept", got);
    check_cycle(100, "R7 new ratio", got);
    // R2 sweep, R8 one pulse per cycle covered by measure
    for (int n = 72; n <= 151; n++) go_int(n, n, "R2 sweep");
    go_int(32767, 32767, "R2 max");
    go_int(0, 72, "R4 clamp zero");
    go_int(71, 72, "R4 clamp 71");
    set_cfg(1'b1, 2000, 0);
    check_cycle(72, "R7 old ratio kept", got);
    check_cycle(1008, "R4 frac clamp", got);
    frac_test(1008, 4095, 6, "R9 frac top");
    frac_test(72, 1, 4096, "R5 F=1");
    frac_test(75, 4095, 300, "R5 F=4095");
    frac_test(90, 1365, 300, "R5 F=1365");
    frac_test(72, 2048, 3, "R5 F=2048");
    frac_test(80, 2048, 2, "R6 cleared acc");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule